// File: doc/BRIEF.md
# Streaming Correlation Key Ranker

This block collects, trace by trace, the running moment sums that a Pearson correlation needs. It pairs one measured power sample per trace with the leakage predictions of every candidate value of a key byte. A trace arrives as a burst of valid beats, one beat for each candidate guess. The first beat of the burst carries the measured sample. Each beat carries that guess's predicted value. The block counts the traces and adds up the sample sum. For every guess it adds up the prediction sum, the sum of squared predictions and the sum of sample-times-prediction products.

An evaluation can be requested at any trace boundary, so the ranking can be observed at whatever trace count the user wants. Accumulation then continues afterwards without losing anything. During an evaluation the block visits one guess per cycle. It forms the covariance numerator and the prediction variance from the sums, and it keeps the guess whose squared numerator over variance is largest. The comparison uses cross-multiplication, so it needs neither a square root nor a division. The sample variance is the same for every guess, so it plays no part in the ranking. At the end the block raises a one-cycle done pulse and presents the winning guess, its numerator and its variance.

Top module: `corr_key_ranker`

## Requirements
- R1: After `rst`, or on any clock edge where `clr` is high, the trace count and all sums become zero and the beat position returns to the first guess. `eval_busy`, `eval_done`, `best_guess`, `best_num` and `best_var` become zero. An evaluation that is running is abandoned and produces no done pulse.
- R2: Valid beats are numbered by their position inside the trace, starting at 0 and wrapping after NG beats. The beat at position g carries the prediction for guess g. The measured sample is taken only from the beat at position 0, and the sample on any other beat has no effect. Cycles with `beat_valid` low may appear anywhere and change nothing.
- R3: With 8-bit samples, 5-bit predictions and NG = 256, the 64-bit sums and scores stay exact for more than 2^14 traces. For example, 20 traces of alternating full-scale samples (255, 0) paired with predictions (31, 0) give a numerator of 790500 and a variance of 96100.
- R4: `eval_req` is accepted only when no evaluation is running and the beat position is 0. A request in the middle of a trace is ignored: `eval_busy` stays low and no done pulse follows.
- R5: While `eval_busy` is high, valid beats are ignored and change neither the sums nor the beat position.
- R6: For each guess, num = N·Σwp − Σw·Σp and var = N·Σp² − (Σp)², both taken as 64-bit two's complement. Only guesses with num > 0 and var > 0 compete. The winner is the one with the largest num²/var, decided by cross-multiplication. A strongly negatively correlated guess therefore never wins.
- R7: On equal scores the lower-numbered guess wins.
- R8: If no guess competes (for example, right after a clear), the result is guess 0 with `best_num` and `best_var` both 0.
- R9: `eval_done` is high for exactly one cycle, no later than NG+4 cycles after the edge that accepts the request. On that same edge `eval_busy` goes low. The result outputs then hold until the next accepted request or clear.
- R10: An evaluation leaves the sums untouched. Traces that arrive afterwards add to them, so a later evaluation ranks the total of all traces since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all sums, the trace count and any running evaluation |
| beat_valid | input | 1 | A prediction beat is present |
| beat_meas | input | W_W | Measured sample, used on the first beat of a trace only |
| beat_pred | input | P_W | Prediction for the guess at the current beat position |
| eval_req | input | 1 | Request to rank all guesses |
| eval_busy | output | 1 | Evaluation in progress |
| eval_done | output | 1 | One-cycle pulse when the result is ready |
| best_guess | output | clog2(NG) | Index of the winning guess |
| best_num | output | ACC_W | Covariance numerator of the winner |
| best_var | output | ACC_W | Prediction variance term of the winner |

## Verification
The assertions watch, on every cycle, the handshake around an evaluation. They check that done is a single pulse that coincides with busy falling unless a clear intervened, that a clear leaves everything idle and zeroed, that the outputs do not move while idle, and that a reported numerator is never negative and is zero exactly when the variance is zero. Which guess wins, the exact sums, the disregard of samples on later beats and of beats during an evaluation, tie breaking, and the rejection of mid-trace requests all depend on data over many traces. Only the scenario-driven scoreboard can show these, by comparing against a model of the sums.

// File: rtl/crk_pkg.sv
package crk_pkg;
  // index of each per-guess moment memory
  localparam int MOM_P    = 0;  // sum of predictions
  localparam int MOM_PP   = 1;  // sum of squared predictions
  localparam int MOM_WP   = 2;  // sum of sample times prediction
  localparam int NUM_MOM  = 3;
endpackage

// File: rtl/crk_front.sv
module crk_front #(
  parameter int NG    = 256,
  parameter int W_W   = 8,
  parameter int P_W   = 5,
  parameter int ACC_W = 64,
  parameter int GW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic             beat_valid,
  input  logic [W_W-1:0]   beat_meas,
  input  logic [P_W-1:0]   beat_pred,
  output logic             beat,
  output logic [GW-1:0]    pos,
  output logic             at_start,
  output logic             upd_vld,
  output logic [GW-1:0]    upd_idx,
  output logic [W_W-1:0]   upd_w,
  output logic [P_W-1:0]   upd_p,
  output logic [ACC_W-1:0] sum_w,
  output logic [ACC_W-1:0] n_tr
);
  logic [W_W-1:0] w_hold;
  logic [W_W-1:0] w_now;

  assign beat     = beat_valid && !hold && !clr;
  assign at_start = (pos == '0);
  assign w_now    = at_start ? beat_meas : w_hold;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos     <= '0;
      w_hold  <= '0;
      sum_w   <= '0;
      n_tr    <= '0;
      upd_vld <= 1'b0;
      upd_idx <= '0;
      upd_w   <= '0;
      upd_p   <= '0;
    end else begin
      upd_vld <= beat;
      if (beat) begin
        upd_idx <= pos;
        upd_w   <= w_now;
        upd_p   <= beat_pred;
        pos     <= (pos == GW'(NG - 1)) ? '0 : pos + GW'(1);
        if (at_start) begin
          w_hold <= beat_meas;
          sum_w  <= sum_w + ACC_W'(beat_meas);
          n_tr   <= n_tr + ACC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/crk_sum_ram.sv
module crk_sum_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_inc,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic             rd_ok;
  logic [DEPTH-1:0] fresh;   // entry written since last clear

  // plain synchronous read and write: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
    if (wr_en && !clr) mem[wr_addr] <= rd_data + wr_inc;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fresh <= '0;
      rd_ok <= 1'b0;
    end else begin
      if (wr_en) fresh[wr_addr] <= 1'b1;
      if (rd_en) rd_ok <= fresh[rd_addr];
    end
  end

  assign rd_data = rd_ok ? rd_q : '0;
endmodule

// File: rtl/crk_score_eval.sv
module crk_score_eval #(
  parameter int NG    = 256,
  parameter int GW    = 8,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             eval_req,
  input  logic             at_start,
  input  logic [ACC_W-1:0] n_tr,
  input  logic [ACC_W-1:0] sum_w,
  input  logic [ACC_W-1:0] rd_p,
  input  logic [ACC_W-1:0] rd_pp,
  input  logic [ACC_W-1:0] rd_wp,
  output logic             rd_en,
  output logic [GW-1:0]    rd_addr,
  output logic             busy,
  output logic             done,
  output logic [GW-1:0]    best_guess,
  output logic [ACC_W-1:0] best_num,
  output logic [ACC_W-1:0] best_var
);
  localparam int SQ_W  = 2 * ACC_W;
  localparam int BIG_W = 3 * ACC_W;

  logic             go, issuing, found;
  logic [GW-1:0]    ev_idx, s1_idx, s2_idx;
  logic             s1_vld, s2_vld, s2_last, cand, win;
  logic [ACC_W-1:0] s2_num, s2_var;
  logic [SQ_W-1:0]  num_sq, best_sq;
  logic [BIG_W-1:0] lhs, rhs;

  assign go      = eval_req && !busy && at_start && !clr;
  assign rd_en   = issuing;
  assign rd_addr = ev_idx;

  // num^2/var > best_num^2/best_var, both denominators positive
  assign num_sq  = SQ_W'(s2_num) * SQ_W'(s2_num);
  assign lhs     = BIG_W'(num_sq) * BIG_W'(best_var);
  assign rhs     = BIG_W'(best_sq) * BIG_W'(s2_var);
  assign cand    = s2_vld && !s2_num[ACC_W-1] && (s2_num != '0) && (s2_var != '0);
  assign win     = cand && (!found || (lhs > rhs));
  assign s2_last = s2_vld && (s2_idx == GW'(NG - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      issuing    <= 1'b0;
      found      <= 1'b0;
      ev_idx     <= '0;
      s1_vld     <= 1'b0;
      s1_idx     <= '0;
      s2_vld     <= 1'b0;
      s2_idx     <= '0;
      s2_num     <= '0;
      s2_var     <= '0;
      best_guess <= '0;
      best_num   <= '0;
      best_var   <= '0;
      best_sq    <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy       <= 1'b1;
        issuing    <= 1'b1;
        ev_idx     <= '0;
        found      <= 1'b0;
        best_guess <= '0;
        best_num   <= '0;
        best_var   <= '0;
        best_sq    <= '0;
      end else if (issuing) begin
        ev_idx <= ev_idx + GW'(1);
        if (ev_idx == GW'(NG - 1)) issuing <= 1'b0;
      end
      // stage 1: memory data valid, stage 2: score terms registered
      s1_vld <= issuing;
      s1_idx <= ev_idx;
      s2_vld <= s1_vld;
      s2_idx <= s1_idx;
      s2_num <= n_tr * rd_wp - sum_w * rd_p;
      s2_var <= n_tr * rd_pp - rd_p * rd_p;
      if (win) begin
        found      <= 1'b1;
        best_guess <= s2_idx;
        best_num   <= s2_num;
        best_var   <= s2_var;
        best_sq    <= num_sq;
      end
      if (s2_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/corr_key_ranker.sv
module corr_key_ranker #(
  parameter int NG    = 256,
  parameter int W_W   = 8,
  parameter int P_W   = 5,
  parameter int ACC_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  beat_valid,
  input  logic [W_W-1:0]        beat_meas,
  input  logic [P_W-1:0]        beat_pred,
  input  logic                  eval_req,
  output logic                  eval_busy,
  output logic                  eval_done,
  output logic [$clog2(NG)-1:0] best_guess,
  output logic [ACC_W-1:0]      best_num,
  output logic [ACC_W-1:0]      best_var
);
  import crk_pkg::*;
  localparam int GW = $clog2(NG);

  logic             beat, at_start, upd_vld, ev_rd_en;
  logic [GW-1:0]    pos, upd_idx, ev_addr, ram_addr;
  logic [W_W-1:0]   upd_w;
  logic [P_W-1:0]   upd_p;
  logic [ACC_W-1:0] sum_w, n_tr;
  logic [ACC_W-1:0] inc [NUM_MOM];
  logic [ACC_W-1:0] rd  [NUM_MOM];

  crk_front #(.NG(NG), .W_W(W_W), .P_W(P_W), .ACC_W(ACC_W), .GW(GW)) i_front (
    .clk(clk), .rst(rst), .clr(clr), .hold(eval_busy),
    .beat_valid(beat_valid), .beat_meas(beat_meas), .beat_pred(beat_pred),
    .beat(beat), .pos(pos), .at_start(at_start),
    .upd_vld(upd_vld), .upd_idx(upd_idx), .upd_w(upd_w), .upd_p(upd_p),
    .sum_w(sum_w), .n_tr(n_tr)
  );

  assign inc[MOM_P]  = ACC_W'(upd_p);
  assign inc[MOM_PP] = ACC_W'(upd_p) * ACC_W'(upd_p);
  assign inc[MOM_WP] = ACC_W'(upd_w) * ACC_W'(upd_p);
  assign ram_addr    = eval_busy ? ev_addr : pos;

  for (genvar k = 0; k < NUM_MOM; k++) begin : g_mom
    crk_sum_ram #(.DEPTH(NG), .AW(GW), .DW(ACC_W)) i_ram (
      .clk(clk), .rst(rst), .clr(clr),
      .rd_en(beat || ev_rd_en), .rd_addr(ram_addr),
      .wr_en(upd_vld), .wr_addr(upd_idx), .wr_inc(inc[k]),
      .rd_data(rd[k])
    );
  end

  crk_score_eval #(.NG(NG), .GW(GW), .ACC_W(ACC_W)) i_eval (
    .clk(clk), .rst(rst), .clr(clr), .eval_req(eval_req), .at_start(at_start),
    .n_tr(n_tr), .sum_w(sum_w),
    .rd_p(rd[MOM_P]), .rd_pp(rd[MOM_PP]), .rd_wp(rd[MOM_WP]),
    .rd_en(ev_rd_en), .rd_addr(ev_addr),
    .busy(eval_busy), .done(eval_done),
    .best_guess(best_guess), .best_num(best_num), .best_var(best_var)
  );
endmodule

// File: rtl/corr_key_ranker_chk.sv
module corr_key_ranker_chk #(
  parameter int ACC_W = 64,
  parameter int GW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             eval_req,
  input logic             eval_busy,
  input logic             eval_done,
  input logic [GW-1:0]    best_guess,
  input logic [ACC_W-1:0] best_num,
  input logic [ACC_W-1:0] best_var
);
  a_r1_clear_idles: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!eval_busy && !eval_done && best_num == '0 && best_var == '0 && best_guess == '0));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    eval_done |=> !eval_done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    eval_done |-> !eval_busy);

  a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
    $fell(eval_busy) |-> (eval_done || $past(clr)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!eval_busy && !eval_req && !clr) |=>
      ($stable(best_guess) && $stable(best_num) && $stable(best_var)));

  a_r6_num_var_pair: assert property (@(posedge clk) disable iff (rst)
    eval_done |-> ((best_num == '0) == (best_var == '0)));

  a_r6_num_not_negative: assert property (@(posedge clk) disable iff (rst)
    eval_done |-> !best_num[ACC_W-1]);
endmodule

bind corr_key_ranker corr_key_ranker_chk #(.ACC_W(ACC_W), .GW($clog2(NG))) i_chk (
  .clk(clk), .rst(rst), .clr(clr), .eval_req(eval_req),
  .eval_busy(eval_busy), .eval_done(eval_done),
  .best_guess(best_guess), .best_num(best_num), .best_var(best_var)
);

// File: tb/test_corr_key_ranker.sv
module test_corr_key_ranker;
  localparam int NG = 256, W_W = 8, P_W = 5, ACC_W = 64, GW = $clog2(NG);
  localparam int KEY = 8'h5A;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic beat_valid = 1'b0, eval_req = 1'b0;
  logic [W_W-1:0] beat_meas = '0;
  logic [P_W-1:0] beat_pred = '0;
  logic eval_busy, eval_done;
  logic [GW-1:0] best_guess;
  logic [ACC_W-1:0] best_num, best_var;

  always #10 clk = ~clk;  // 50 MHz

  corr_key_ranker #(.NG(NG), .W_W(W_W), .P_W(P_W), .ACC_W(ACC_W)) i_corr_key_ranker (
    .clk(clk), .rst(rst), .clr(clr), .beat_valid(beat_valid), .beat_meas(beat_meas),
    .beat_pred(beat_pred), .eval_req(eval_req), .eval_busy(eval_busy), .eval_done(eval_done),
    .best_guess(best_guess), .best_num(best_num), .best_var(best_var));

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint m_sp [NG], m_spp [NG], m_swp [NG];
  longint m_sw = 0, m_n = 0, cur_w = 0;

  typedef struct { int guess; longint num; longint vr; longint start; string tag; } exp_t;
  exp_t q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_eq(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int f_pred(int g, int t, int mode);
    case (mode)
      2:       return (t * 11 + 3) % 32;
      3:       return (((g % 2) == 0) == ((t % 2) == 0)) ? 31 : 0;
      default: return ((g * 73) ^ (t * 151) ^ ((g * t) >> 2) ^ ((g >> 3) * t)) & 31;
    endcase
  endfunction

  function automatic int f_samp(int t, int mode);
    case (mode)
      1:       return 240 - 6 * f_pred(KEY, t, 0) - (t * 5) % 30;
      2:       return 6 * f_pred(0, t, 2) + (t % 3) * 4;
      3:       return ((t % 2) == 0) ? 255 : 0;
      default: return 6 * f_pred(KEY, t, 0) + (t * 7) % 40;
    endcase
  endfunction

  task automatic model_clear();
    for (int g = 0; g < NG; g++) begin m_sp[g] = 0; m_spp[g] = 0; m_swp[g] = 0; end
    m_sw = 0; m_n = 0; cur_w = 0;
  endtask

  // R2: beats with gaps and meaningless samples on every non-first beat
  task automatic drive_beats(int t, int g0, int g1, int mode);
    for (int g = g0; g <= g1; g++) begin
      int p;
      if (g % 37 == 5) begin @(negedge clk); beat_valid = 1'b0; end
      @(negedge clk);
      p = f_pred(g, t, mode);
      beat_valid = 1'b1;
      beat_pred  = P_W'(p);
      beat_meas  = (g == 0) ? W_W'(f_samp(t, mode)) : W_W'((g * 97 + t * 13) & 255);
      if (g == 0) begin cur_w = f_samp(t, mode); m_sw += cur_w; m_n++; end
      m_sp[g]  += p;
      m_spp[g] += p * p;
      m_swp[g] += cur_w * p;
    end
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic push_expect(string tag);
    exp_t e;
    logic [191:0] l, r;
    bit fnd = 0;
    e.guess = 0; e.num = 0; e.vr = 0; e.tag = tag; e.start = cyc;
    for (int g = 0; g < NG; g++) begin
      longint num, vr;
      num = m_n * m_swp[g] - m_sw * m_sp[g];
      vr  = m_n * m_spp[g] - m_sp[g] * m_sp[g];
      if (num > 0 && vr > 0) begin
        l = 192'(num) * 192'(num) * 192'(e.vr);
        r = 192'(e.num) * 192'(e.num) * 192'(vr);
        if (!fnd || l > r) begin fnd = 1; e.guess = g; e.num = num; e.vr = vr; end
      end
    end
    q.push_back(e);
  endtask

  task automatic do_eval(string tag);
    push_expect(tag);
    @(negedge clk); eval_req = 1'b1;
    @(negedge clk); eval_req = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (eval_done === 1'b1) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk_eq(e.tag, "best_guess", longint'(best_guess), e.guess);
        chk_eq(e.tag, "best_num", longint'(best_num), e.num);
        chk_eq(e.tag, "best_var", longint'(best_var), e.vr);
        checks++;
        if (cyc - e.start - 1 > NG + 4) begin
          errors++;
          $display("FAIL R9 latency actual=%0d expected<=%0d", cyc - e.start - 1, NG + 4);
        end
        chk_eq("R9", "busy at done", longint'(eval_busy), 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1", "busy after reset", longint'(eval_busy), 0);
    chk_eq("R1", "done after reset", longint'(eval_done), 0);
    chk_eq("R1", "guess after reset", longint'(best_guess), 0);
    chk_eq("R1", "num after reset", longint'(best_num), 0);

    do_eval("R8 empty");

    for (int t = 0; t < 24; t++) drive_beats(t, 0, NG - 1, 0);
    do_eval("R2/R6 correlated");

    for (int t = 24; t < 32; t++) drive_beats(t, 0, NG - 1, 0);
    do_eval("R10 continued");

    // R5: beats offered while busy are dropped
    push_expect("R5 busy beats");
    @(negedge clk); eval_req = 1'b1;
    @(negedge clk); eval_req = 1'b0;
    do begin
      beat_valid = eval_busy;
      beat_pred  = 5'd31;
      beat_meas  = 8'hFF;
      @(negedge clk);
    end while (q.size() != 0);
    beat_valid = 1'b0;
    do_eval("R5 sums unchanged");

    // R4: request inside a trace is ignored
    drive_beats(32, 0, 9, 0);
    @(negedge clk); eval_req = 1'b1;
    @(negedge clk); eval_req = 1'b0;
    @(negedge clk);
    chk_eq("R4", "busy after mid-trace request", longint'(eval_busy), 0);
    drive_beats(32, 10, NG - 1, 0);
    do_eval("R4 after completed trace");

    // R1: clear aborts a running evaluation
    @(negedge clk); eval_req = 1'b1;
    @(negedge clk); eval_req = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R1", "busy during eval", longint'(eval_busy), 1);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    chk_eq("R1", "busy after clear", longint'(eval_busy), 0);
    chk_eq("R1", "num after clear", longint'(best_num), 0);
    chk_eq("R1", "var after clear", longint'(best_var), 0);
    repeat (300) @(negedge clk);
    do_eval("R1/R8 after clear");

    // R7: identical predictions for every guess
    for (int t = 0; t < 12; t++) drive_beats(t, 0, NG - 1, 2);
    do_eval("R7 tie");
    chk_eq("R7", "tie winner", longint'(best_guess), 0);

    // R6: anti-correlated key never wins
    clr = 1'b1; @(negedge clk); clr = 1'b0; model_clear();
    for (int t = 0; t < 16; t++) drive_beats(t, 0, NG - 1, 1);
    do_eval("R6 negative");
    checks++;
    if (best_guess == GW'(KEY)) begin
      errors++;
      $display("FAIL R6 negative key won actual=%0d expected!=%0d", best_guess, KEY);
    end

    // R3: full-scale values
    clr = 1'b1; @(negedge clk); clr = 1'b0; model_clear();
    for (int t = 0; t < 20; t++) drive_beats(t, 0, NG - 1, 3);
    do_eval("R3 full scale");
    chk_eq("R3", "full-scale num", longint'(best_num), 790500);
    chk_eq("R3", "full-scale var", longint'(best_var), 96100);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule